// File: doc/BRIEF.md
# Hashed Pending Interest Table

This block keeps track of outstanding requests in a named-data packet switch. Each request packet (an Interest) carries a fixed-width name partition, which is a hash of its name components, and arrives on one ingress port. The table records that port against the name. When the matching reply (a Data packet) comes back, the table returns the set of ports that asked for it. A downstream replicator then sends one copy to each of those ports. Data with no matching record is marked for drop. The table also reports whether an Interest is the first one for its name, and so must be forwarded upstream. An Interest that only joins an existing record is not forwarded again.

Storage is two register arrays indexed directly by the partition modulo the entry count. One array holds a port bitmap per entry. The other holds the full partition as a tag. Because of the tag, two names that share an index can never read or corrupt each other's bitmap. Every update happens in the data path, one request per cycle, with no control-plane writes. The response is registered and appears in the cycle after the request.

Top module: `pit_table`

## Requirements
- R1: After reset every entry is empty and `rsp_valid` is low, so a Data request sent right after reset is answered with drop.
- R2: The entry index of partition P is P modulo `DEPTH`. Two partitions with the same remainder share one entry, and the stored tag tells them apart.
- R3: An Interest to an empty entry stores its partition. The entry's port bitmap becomes only the ingress port's bit, where bit i stands for port i. The response has fwd=1, hit=0, drop=0 and ports equal to that single bit.
- R4: An Interest whose partition matches the valid stored tag ORs its port bit into the bitmap. The response has hit=1, fwd=0, drop=0 and ports equal to the merged bitmap.
- R5: An Interest whose index holds a valid entry with a different tag replaces that entry. It writes the new tag and sets the bitmap to only the new port's bit. The response has fwd=1 and hit=0.
- R6: A Data request whose partition matches a valid tag responds with hit=1, drop=0 and ports equal to the stored bitmap.
- R7: A Data hit clears its entry in the same update, so a second Data request for the same partition is dropped.
- R8: A Data request that finds an empty entry or a different tag responds with drop=1, hit=0 and ports=0. It leaves the entry unchanged.
- R9: A response (`rsp_valid`=1) follows each request exactly one cycle later. A cycle without a request gives `rsp_valid`=0 and changes no entry.
- R10: An Interest whose port number is `NUM_PORTS` or above is answered with drop=1 and fwd=0. It leaves the table unchanged.
- R11: A Data response never asserts fwd.
- R12: A request sees every update made by the request in the cycle before it, even when both requests use the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_is_data | input | 1 | 1 = Data request, 0 = Interest |
| req_part | input | PART_W | Name partition (hash) |
| req_port | input | PORT_W | Ingress port number |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Data served, or Interest joined an existing record |
| rsp_drop | output | 1 | Request dropped (Data miss or illegal port) |
| rsp_fwd | output | 1 | Interest must be forwarded upstream |
| rsp_ports | output | NUM_PORTS | Port bitmap (bit i = port i) |

## Verification
The table is driven with single Interests to empty entries and with repeated Interests that join the same name. Partitions that share an index test whether the tag keeps names apart, both when a Data miss must leave the old entry intact and when an Interest takes the entry over. Back-to-back requests to one entry show that each request sees the previous update. Illegal port numbers and Data requests repeated after a hit show that the table stays unchanged or cleared as required.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic {
      OP_INTEREST = 1'b0,
      OP_DATA     = 1'b1
   } pit_op_e;
endpackage

// File: rtl/pit_index.sv
module pit_index #(
   parameter int PART_W = 16,
   parameter int DEPTH  = 12,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [PART_W-1:0] part,
   output logic [IDX_W-1:0]  idx
);
   generate
      if (PART_W < IDX_W) begin : g_bad_width
         $error("pit_index: PART_W narrower than index");
      end
      if (DEPTH == 1) begin : g_single
         assign idx = '0;
      end else if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         // power-of-two depth: modulo is a plain bit select
         assign idx = part[IDX_W-1:0];
      end else begin : g_modulo
         localparam logic [PART_W-1:0] DEPTH_P = PART_W'(DEPTH);
         logic [PART_W-1:0] rem;
         assign rem = part % DEPTH_P;
         assign idx = rem[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/pit_store.sv
module pit_store #(
   parameter int PART_W    = 16,
   parameter int NUM_PORTS = 6,
   parameter int DEPTH     = 12,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [PART_W-1:0]    rd_tag,
   output logic [NUM_PORTS-1:0] rd_ports,
   output logic                 rd_valid,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [PART_W-1:0]    wr_tag,
   input  logic [NUM_PORTS-1:0] wr_ports,
   input  logic                 wr_valid
);
   logic [PART_W-1:0]    tag_q   [DEPTH];
   logic [NUM_PORTS-1:0] ports_q [DEPTH];
   logic [DEPTH-1:0]     valid_q;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_q[e]   <= '0;
               ports_q[e] <= '0;
               valid_q[e] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
               tag_q[e]   <= wr_tag;
               ports_q[e] <= wr_ports;
               valid_q[e] <= wr_valid;
            end
         end
      end
   endgenerate

   assign rd_tag   = tag_q[rd_idx];
   assign rd_ports = ports_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

   // R7: a clearing write leaves the entry invalid on the next cycle
   a_r7_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_valid) |=> !valid_q[$past(wr_idx)]);
   // R3: a validating write never leaves an empty bitmap behind
   a_r3_valid_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_valid) |=> (ports_q[$past(wr_idx)] != '0));
endmodule

// File: rtl/pit_decide.sv
module pit_decide
   import pit_pkg::*;
#(
   parameter int PART_W    = 16,
   parameter int NUM_PORTS = 6,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 req_valid,
   input  pit_op_e              req_op,
   input  logic [PART_W-1:0]    req_part,
   input  logic [PORT_W-1:0]    req_port,
   input  logic [PART_W-1:0]    rd_tag,
   input  logic [NUM_PORTS-1:0] rd_ports,
   input  logic                 rd_valid,
   output logic                 wr_en,
   output logic [PART_W-1:0]    wr_tag,
   output logic [NUM_PORTS-1:0] wr_ports,
   output logic                 wr_valid,
   output logic                 nx_hit,
   output logic                 nx_drop,
   output logic                 nx_fwd,
   output logic [NUM_PORTS-1:0] nx_ports
);
   logic                 port_ok;
   logic                 tag_eq;
   logic [NUM_PORTS-1:0] port_bit;

   generate
      if (NUM_PORTS == (1 << PORT_W)) begin : g_full_port_range
         assign port_ok = 1'b1;
      end else begin : g_partial_port_range
         assign port_ok = ({1'b0, req_port} < (PORT_W + 1)'(NUM_PORTS));
      end
   endgenerate

   assign port_bit = NUM_PORTS'(1) << req_port;
   assign tag_eq   = rd_valid && (rd_tag == req_part);

   always_comb begin
      wr_en    = 1'b0;
      wr_tag   = req_part;
      wr_ports = '0;
      wr_valid = 1'b0;
      nx_hit   = 1'b0;
      nx_drop  = 1'b0;
      nx_fwd   = 1'b0;
      nx_ports = '0;
      if (req_valid) begin
         unique case (req_op)
            OP_INTEREST: begin
               if (!port_ok) begin
                  nx_drop = 1'b1;
               end else if (tag_eq) begin
                  // join an existing record; forward only if nothing pending
                  wr_en    = 1'b1;
                  wr_ports = rd_ports | port_bit;
                  wr_valid = 1'b1;
                  nx_hit   = 1'b1;
                  nx_fwd   = (rd_ports == '0);
                  nx_ports = rd_ports | port_bit;
               end else begin
                  // empty entry or collision: take the entry over
                  wr_en    = 1'b1;
                  wr_ports = port_bit;
                  wr_valid = 1'b1;
                  nx_fwd   = 1'b1;
                  nx_ports = port_bit;
               end
            end
            OP_DATA: begin
               if (tag_eq) begin
                  wr_en    = 1'b1;
                  wr_tag   = rd_tag;
                  wr_ports = '0;
                  wr_valid = 1'b0;
                  nx_hit   = 1'b1;
                  nx_ports = rd_ports;
               end else begin
                  nx_drop = 1'b1;
               end
            end
            default: nx_drop = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/pit_table.sv
module pit_table
   import pit_pkg::*;
#(
   parameter int PART_W    = 16,
   parameter int NUM_PORTS = 6,
   parameter int DEPTH     = 12,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_is_data,
   input  logic [PART_W-1:0]    req_part,
   input  logic [PORT_W-1:0]    req_port,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic                 rsp_drop,
   output logic                 rsp_fwd,
   output logic [NUM_PORTS-1:0] rsp_ports
);
   generate
      if (DEPTH < 1 || DEPTH > 4096) begin : g_bad_depth
         $error("pit_table: DEPTH out of range");
      end
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("pit_table: NUM_PORTS must be positive");
      end
      if (PART_W < 1) begin : g_bad_part
         $error("pit_table: PART_W must be positive");
      end
   endgenerate

   pit_op_e              req_op;
   logic [IDX_W-1:0]     idx;
   logic [PART_W-1:0]    rd_tag;
   logic [NUM_PORTS-1:0] rd_ports;
   logic                 rd_valid;
   logic                 wr_en;
   logic [PART_W-1:0]    wr_tag;
   logic [NUM_PORTS-1:0] wr_ports;
   logic                 wr_valid;
   logic                 nx_hit, nx_drop, nx_fwd;
   logic [NUM_PORTS-1:0] nx_ports;
   pit_op_e              rsp_op_q;

   assign req_op = req_is_data ? OP_DATA : OP_INTEREST;

   pit_index #(.PART_W(PART_W), .DEPTH(DEPTH)) u_index (
      .part (req_part),
      .idx  (idx)
   );

   pit_store #(.PART_W(PART_W), .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (idx),
      .rd_tag   (rd_tag),
      .rd_ports (rd_ports),
      .rd_valid (rd_valid),
      .wr_en    (wr_en),
      .wr_idx   (idx),
      .wr_tag   (wr_tag),
      .wr_ports (wr_ports),
      .wr_valid (wr_valid)
   );

   pit_decide #(.PART_W(PART_W), .NUM_PORTS(NUM_PORTS)) u_decide (
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_part  (req_part),
      .req_port  (req_port),
      .rd_tag    (rd_tag),
      .rd_ports  (rd_ports),
      .rd_valid  (rd_valid),
      .wr_en     (wr_en),
      .wr_tag    (wr_tag),
      .wr_ports  (wr_ports),
      .wr_valid  (wr_valid),
      .nx_hit    (nx_hit),
      .nx_drop   (nx_drop),
      .nx_fwd    (nx_fwd),
      .nx_ports  (nx_ports)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_drop  <= 1'b0;
         rsp_fwd   <= 1'b0;
         rsp_ports <= '0;
         rsp_op_q  <= OP_INTEREST;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= nx_hit;
         rsp_drop  <= nx_drop;
         rsp_fwd   <= nx_fwd;
         rsp_ports <= nx_ports;
         rsp_op_q  <= req_op;
      end
   end

   // R9: each request is answered exactly one cycle later
   a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r9_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R11: Data responses never request upstream forwarding
   a_r11_data_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_op_q == OP_DATA) |-> !rsp_fwd);
   // R8: a drop carries no ports and no hit
   a_r8_drop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_drop |-> (rsp_ports == '0 && !rsp_hit));
   // R3 / R5: a forwarded Interest names exactly one port
   a_r5_fwd_single_port: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fwd |-> ($countones(rsp_ports) == 1));
   // R6: a hit always carries at least one port
   a_r6_hit_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_ports != '0));
endmodule

// File: tb/test_pit_table.sv
module test_pit_table;
   localparam int CLK_PERIOD = 10;
   localparam int PART_W     = 16;
   localparam int NUM_PORTS  = 6;
   localparam int DEPTH      = 12;
   localparam int PORT_W     = 3;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req_valid = 1'b0;
   logic                 req_is_data = 1'b0;
   logic [PART_W-1:0]    req_part = '0;
   logic [PORT_W-1:0]    req_port = '0;
   logic                 rsp_valid, rsp_hit, rsp_drop, rsp_fwd;
   logic [NUM_PORTS-1:0] rsp_ports;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pit_table #(.PART_W(PART_W), .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)) i_pit_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_is_data (req_is_data),
      .req_part    (req_part),
      .req_port    (req_port),
      .rsp_valid   (rsp_valid),
      .rsp_hit     (rsp_hit),
      .rsp_drop    (rsp_drop),
      .rsp_fwd     (rsp_fwd),
      .rsp_ports   (rsp_ports)
   );

   task automatic check(input string what, input int got, input int exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
      end
   endtask

   // one request; outputs sampled at the next falling edge (one register)
   task automatic req(input bit is_data, input int part, input int port);
      req_valid   = 1'b1;
      req_is_data = is_data;
      req_part    = PART_W'(part);
      req_port    = PORT_W'(port);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input int hit, input int drop,
                             input int fwd, input int ports);
      check({tag, " valid"}, int'(rsp_valid), 1);
      check({tag, " hit"},   int'(rsp_hit),   hit);
      check({tag, " drop"},  int'(rsp_drop),  drop);
      check({tag, " fwd"},   int'(rsp_fwd),   fwd);
      check({tag, " ports"}, int'(rsp_ports), ports);
   endtask

   task automatic t_reset;
      check("R1 rsp_valid after reset", int'(rsp_valid), 0);
      req(1'b1, 5, 0);
      expect_rsp("R1 data after reset", 0, 1, 0, 0);
   endtask

   task automatic t_first_and_join;
      req(1'b0, 5, 2);
      expect_rsp("R3 first interest", 0, 0, 1, 'h04);
      req(1'b0, 5, 4);
      expect_rsp("R4 join interest", 1, 0, 0, 'h14);
      req(1'b0, 5, 2);
      expect_rsp("R4 repeat port", 1, 0, 0, 'h14);
   endtask

   task automatic t_idle;
      @(negedge clk);
      check("R9 idle no response", int'(rsp_valid), 0);
   endtask

   task automatic t_data_serve;
      req(1'b1, 17, 0);      // 17 mod 12 = 5, different tag
      expect_rsp("R8 R2 collide data miss", 0, 1, 0, 0);
      req(1'b1, 5, 0);
      expect_rsp("R6 R11 data hit", 1, 0, 0, 'h14);
      req(1'b1, 5, 0);
      expect_rsp("R7 data after clear", 0, 1, 0, 0);
   endtask

   task automatic t_replace;
      req(1'b0, 30, 1);      // index 6
      expect_rsp("R3 interest 30", 0, 0, 1, 'h02);
      req(1'b0, 42, 3);      // 42 mod 12 = 6
      expect_rsp("R5 replace", 0, 0, 1, 'h08);
      req(1'b1, 30, 0);
      expect_rsp("R5 old name gone", 0, 1, 0, 0);
      req(1'b1, 42, 0);
      expect_rsp("R5 new name served", 1, 0, 0, 'h08);
   endtask

   task automatic t_bad_port;
      req(1'b0, 7, 6);
      expect_rsp("R10 illegal port", 0, 1, 0, 0);
      req(1'b1, 7, 0);
      expect_rsp("R10 table untouched", 0, 1, 0, 0);
      req(1'b0, 7, 0);
      expect_rsp("R10 legal interest", 0, 0, 1, 'h01);
      req(1'b0, 7, 7);
      expect_rsp("R10 illegal join", 0, 1, 0, 0);
      req(1'b1, 7, 0);
      expect_rsp("R10 bitmap intact", 1, 0, 0, 'h01);
   endtask

   task automatic t_back_to_back;
      req(1'b0, 100, 5);     // 100 mod 12 = 4
      expect_rsp("R12 first", 0, 0, 1, 'h20);
      req(1'b0, 100, 0);
      expect_rsp("R12 second sees first", 1, 0, 0, 'h21);
      req(1'b1, 100, 0);
      expect_rsp("R12 data sees both", 1, 0, 0, 'h21);
   endtask

   task automatic t_independent;
      req(1'b0, 8, 0);
      req(1'b0, 9, 1);
      req(1'b1, 8, 0);
      expect_rsp("R2 separate index 8", 1, 0, 0, 'h01);
      req(1'b1, 9, 0);
      expect_rsp("R2 separate index 9", 1, 0, 0, 'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_and_join();
      t_idle();
      t_data_serve();
      t_replace();
      t_bad_port();
      t_back_to_back();
      t_independent();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule